// File: doc/BRIEF.md
# Pixel-interleaved to planar colour reorderer

This block takes a byte stream in which the four ink channels of a print pixel arrive one after another (cyan, magenta, yellow, black of pixel 0, then of pixel 1, and so on) and emits it in planar order for each group of four pixels. For each group it sends the four cyan bytes first, then the four magenta bytes, then yellow, then black. One byte is accepted and one byte is produced per clock. There are no stalls. Groups of sixteen bytes may follow each other with no gap.

Each pixel's four bytes are collected into a four-lane word. The word is rotated right by the pixel's position within the group and pushed into four per-lane shift registers. The read side picks one lane and one tap depth in every cycle. Both choices come from a single 4-bit position counter, so each shift register acts as a delay line whose length changes from cycle to cycle. Every bit of the byte has its own copy of this structure. The data storage has no reset, so an FPGA can map it into shift-register primitives.

A group opens with the first valid byte that arrives while the block is idle, or with the byte that directly follows the last byte of the previous group. Every group must be sixteen consecutive valid bytes.

Top module: `cmyk_turn`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it is released, `out_valid`, `out_first` and `out_byte` are 0.
- R2: Output byte m of a group (m = 0..15) equals input byte 4*(m mod 4) + (m div 4) of the same group. The input byte index is 4*pixel + channel, with channel 0 = cyan, 1 = magenta, 2 = yellow, 3 = black. The output order is therefore all cyan bytes first, then magenta, yellow and black, each in pixel order 0..3.
- R3: Each output byte appears exactly 17 clock cycles after the input byte that opened its group, plus its own slot index m.
- R4: `out_first` is high exactly in the cycle that carries output byte 0 of a group, and only while `out_valid` is high.
- R5: Back-to-back input groups give an unbroken run of `out_valid`, 16 cycles per group. `out_valid` only falls at a group boundary.
- R6: After an idle gap of at least 17 cycles, a new group is reordered and timed exactly as the first group after reset.
- R7: Every bit of the byte follows the same permutation independently of the others. Bytes whose bit planes differ come out bit-exact.
- R8: The number of valid output bytes equals the number of valid input bytes. No output byte appears without a matching input byte in flight, and at most 17 bytes are in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is present this cycle |
| in_byte | input | W (8) | Channel byte in pixel-interleaved order |
| out_valid | output | 1 | Output byte is present this cycle |
| out_first | output | 1 | Marks output byte 0 (first cyan) of a group |
| out_byte | output | W (8) | Channel byte in planar order |

## Verification
The first group uses marker bytes that encode pixel and channel in separate nibbles. A wrong lane or a wrong tap therefore shows up as a readable misplaced label, not just a mismatch. Random groups sent back to back test the handover between one group being read out and the next being written into the same shift registers. Groups whose bytes are built so that each bit plane differs catch slices wired to the wrong bit. A restart after a long idle gap shows that the drain logic stops the position counter at a group boundary.

// File: rtl/cmyk_turn_pkg.sv
package cmyk_turn_pkg;
  localparam int NCH   = 4;              // channels per pixel = pixels per group
  localparam int CW    = $clog2(NCH);    // channel / pixel index width
  localparam int GRP   = NCH * NCH;      // bytes per group
  localparam int GW    = $clog2(GRP);    // position counter width
  localparam int TAPS  = 2 * NCH - 1;    // distinct read depths
  localparam int TW    = $clog2(TAPS);   // tap index width
  localparam int DEPTH = 1 << TW;        // per-lane shift register length
  localparam int LAT   = GRP + 1;        // first-in to first-out cycles

  // lane holding channel ch of pixel px after the per-pixel rotation
  function automatic logic [CW-1:0] lane_of(input logic [CW-1:0] ch,
                                            input logic [CW-1:0] px);
    return ch + px;
  endfunction

  // pixel writes since pixel px was pushed, at output slot NCH*ch+px
  function automatic logic [TW-1:0] tap_of(input logic [CW-1:0] ch,
                                           input logic [CW-1:0] px);
    return TW'(NCH - 1) - TW'(px) + TW'(ch);
  endfunction
endpackage

// File: rtl/cmyk_turn_ctl.sv
module cmyk_turn_ctl
  import cmyk_turn_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          run,
  output logic [GW-1:0] pos,
  output logic          out_valid,
  output logic          out_first
);
  logic [GW-1:0]  pos_q;
  logic [LAT-1:0] vld_q;
  logic [LAT-1:0] fst_q;
  logic           pend;

  // a group is still draining while any of its words sits in the first LAT-1 stages
  assign pend = |vld_q[LAT-2:0];
  assign run  = (pos_q != '0) | in_valid | pend;
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      vld_q <= '0;
      fst_q <= '0;
    end else begin
      if (run) pos_q <= pos_q + 1'b1;
      vld_q <= {vld_q[LAT-2:0], in_valid};
      fst_q <= {fst_q[LAT-2:0], in_valid && (pos_q == '0)};
    end
  end

  assign out_valid = vld_q[LAT-1];
  assign out_first = fst_q[LAT-1];
endmodule

// File: rtl/cmyk_turn_slice.sv
module cmyk_turn_slice
  import cmyk_turn_pkg::*;
(
  input  logic          clk,
  input  logic          run,
  input  logic [GW-1:0] pos,
  input  logic          din,
  output logic          dout
);
  logic [CW-1:0]    wr_ch, wr_px, rd_ch, rd_px;
  logic [NCH-2:0]   hold;
  logic [NCH-1:0]   word, rot;
  logic [DEPTH-1:0] lane [NCH];

  // write side: position = NCH*pixel + channel
  assign wr_ch = pos[CW-1:0];
  assign wr_px = pos[GW-1:CW];
  // read side: position = NCH*channel + pixel
  assign rd_ch = pos[GW-1:CW];
  assign rd_px = pos[CW-1:0];

  assign word = {din, hold};

  // barrel rotation: channel c of pixel p lands in lane (c + p) mod NCH
  always_comb begin
    for (int j = 0; j < NCH; j++) rot[j] = word[CW'(j) - wr_px];
  end

  always_ff @(posedge clk) begin
    if (run) begin
      for (int j = 0; j < NCH - 1; j++)
        if (wr_ch == CW'(j)) hold[j] <= din;
      if (wr_ch == CW'(NCH - 1))
        for (int j = 0; j < NCH; j++) lane[j] <= {lane[j][DEPTH-2:0], rot[j]};
    end
  end

  // dynamic-length read: lane and depth both follow the slot counter
  assign dout = lane[lane_of(rd_ch, rd_px)][tap_of(rd_ch, rd_px)];
endmodule

// File: rtl/cmyk_turn.sv
module cmyk_turn
  import cmyk_turn_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_byte,
  output logic         out_valid,
  output logic         out_first,
  output logic [W-1:0] out_byte
);
  logic          run;
  logic [GW-1:0] pos;
  logic [W-1:0]  slice_out;
  logic [W-1:0]  byte_q;

  cmyk_turn_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .run       (run),
    .pos       (pos),
    .out_valid (out_valid),
    .out_first (out_first)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    cmyk_turn_slice u_slice (
      .clk  (clk),
      .run  (run),
      .pos  (pos),
      .din  (in_byte[b]),
      .dout (slice_out[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)      byte_q <= '0;
    else if (run) byte_q <= slice_out;
  end

  assign out_byte = byte_q;
endmodule

// File: rtl/cmyk_turn_chk.sv
module cmyk_turn_chk
  import cmyk_turn_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_first
);
  logic [GW-1:0] slot_q;
  logic [5:0]    flight_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      flight_q <= '0;
    end else begin
      if (out_valid) slot_q <= slot_q + 1'b1;
      flight_q <= flight_q + 6'(in_valid) - 6'(out_valid);
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_first));

  a_r4_first_is_valid: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid);

  a_r4_first_at_slot0: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_first == (slot_q == '0)));

  a_r5_whole_groups: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (slot_q == '0));

  a_r8_flight_bound: assert property (@(posedge clk) disable iff (rst)
    flight_q <= 6'(LAT));

  a_r8_no_phantom: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flight_q != '0));
endmodule

bind cmyk_turn cmyk_turn_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_first (out_first)
);

// File: tb/cmyk_turn_bench.sv
module cmyk_turn_bench;
  localparam int NG = 6;
  // output slot -> input index inside a group (R2)
  localparam int SRC_OF [16] = '{0, 4, 8, 12, 1, 5, 9, 13, 2, 6, 10, 14, 3, 7, 11, 15};
  // per group: pattern kind (0 marker, 1 random, 2 bit-plane) and idle cycles before it
  localparam int KIND [NG] = '{0, 1, 1, 2, 1, 2};
  localparam int GAP  [NG] = '{0, 0, 0, 0, 25, 40};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       out_valid, out_first;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_sent = 0;
  int n_out = 0;
  logic [7:0] sent [0:NG*16-1];
  int grp_cyc [NG];
  int out_cyc [NG*16];
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  cmyk_turn u_cmyk_turn (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_first(out_first), .out_byte(out_byte)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send_group(input int g);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] v;
      @(negedge clk);
      if (k == 0) grp_cyc[g] = cyc;
      case (KIND[g])
        0:       v = 8'((k / 4) * 16 + (k % 4));
        1:       v = 8'($urandom);
        default: v = 8'(k * 37) ^ 8'hA5 ^ {8{g[0]}};
      endcase
      in_valid = 1'b1;
      in_byte  = v;
      sent[n_sent] = v;
      n_sent++;
    end
  endtask

  // output monitor, sampling mid high phase
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (!rst && out_valid && n_out < NG*16) begin
        int g, m, exp;
        g = n_out / 16;
        m = n_out % 16;
        exp = sent[16*g + SRC_OF[m]];
        out_cyc[n_out] = cyc;
        if (KIND[g] == 2) check(out_byte == 8'(exp), "R7 bit-plane data", out_byte, exp);
        else              check(out_byte == 8'(exp), "R2 planar data", out_byte, exp);
        check(out_first == (m == 0), "R4 first flag", out_first, (m == 0));
        if (m == 0) begin
          if (GAP[g] > 0)
            check(cyc == grp_cyc[g] + 17, "R6 restart latency", cyc - grp_cyc[g], 17);
          else
            check(cyc == grp_cyc[g] + 17, "R3 latency", cyc - grp_cyc[g], 17);
        end else begin
          check(prev_valid, "R5 no gap in group", prev_valid, 1);
        end
        n_out++;
      end else if (!rst) begin
        if (out_first) check(1'b0, "R4 first without valid", out_first, 0);
      end
      prev_valid = out_valid;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", n_out, NG*16);
      finish_run();
    end
  end

  initial begin
    // R1: quiet during reset
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(out_first == 1'b0, "R1 reset first", out_first, 0);
    check(out_byte == 8'h00, "R1 reset byte", out_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_byte == 8'h00, "R1 after release", out_valid, 0);

    // table walk: groups with their kind and leading gap
    for (int g = 0; g < NG; g++) begin
      if (GAP[g] > 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (GAP[g] - 1) @(negedge clk);
      end
      send_group(g);
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (60) @(negedge clk);

    // directed: totals and continuity
    check(n_out == NG*16, "R8 output count", n_out, NG*16);
    check(out_cyc[63] - out_cyc[0] == 63, "R5 back-to-back run", out_cyc[63] - out_cyc[0], 63);
    check(out_valid == 1'b0, "R8 idle after drain", out_valid, 0);

    // directed: reset again clears outputs
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0 && out_first == 1'b0, "R1 second reset", out_valid, 0);
    done = 1'b1;
    finish_run();
  end
endmodule